// File: doc/BRIEF.md
# Three-Level Nested Interrupt Arbiter

The block decides which of eight interrupt vectors the CPU is sent to, and when. Each vector has one request line, one mask bit and one level-select bit. From these the block works out a priority level for every vector: highest, high or low. Only the first two vectors can reach the highest level. The other six can reach high at most. The eligible request with the best priority is presented to the CPU as a request line together with the address of its vector. The vector addresses lie on a fixed map that starts at 0x03 and steps by 8.

The block also keeps track of nesting. Accepting a vector marks its level as active. A return-from-interrupt pulse retires the most recently activated level. A new request breaks in only when its level is strictly above the level now being serviced. When no level is active, any unmasked request can be taken. Once raised, the request to the CPU stays up until the CPU acknowledges it. The vector address is frozen at that acknowledge.

Top module: `irq_nest_arb`

## Requirements
- R1: While reset is asserted and after it is released with no requests, `cpu_irq` is 0 and `vec_addr` is 0x00.
- R2: Vector i (0..7) is reported as address 0x03 + 8*i, giving 0x03, 0x0B, ... 0x3B.
- R3: When `lvl_hi[i]`=1 the vector is at the highest level if i<2, or at the high level if i>=2. When `lvl_hi[i]`=0 it is at the low level. Among eligible requests the highest level wins over high, and high wins over low.
- R4: Among eligible requests at the same level, the lowest vector index wins.
- R5: A request whose `irq_mask[i]`=1 takes no part in arbitration.
- R6: While a level is being serviced, a request at the same or a lower level does not raise `cpu_irq`. A request at a strictly higher level does.
- R7: `cpu_irq` rises on the clock edge after an eligible request appears. It then stays high until it is acknowledged, even if the request is removed. While it is pending, `vec_addr` follows the best eligible request.
- R8: `cpu_ack` while `cpu_irq`=1 drops `cpu_irq` on that edge, makes the pending level active, and keeps `vec_addr` unchanged on that edge whatever the requests are doing.
- R9: A `cpu_reti` pulse retires the most recently activated level. With no level active, `cpu_reti` has no effect.
- R10: `cpu_ack` while `cpu_irq`=0 is ignored and activates no level.
- R11: If `cpu_ack` (with `cpu_irq`=1) and `cpu_reti` occur in the same cycle, the acknowledge is applied and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_req | input | 8 | Request line per vector |
| irq_mask | input | 8 | Per-vector mask, 1 blocks the vector |
| lvl_hi | input | 8 | Per-vector level select (see R3) |
| cpu_ack | input | 1 | CPU acknowledge of the pending request |
| cpu_reti | input | 1 | Return-from-interrupt pulse |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| vec_addr | output | 8 | Address of the selected vector |

## Verification
The bench targets four kinds of mistake:
- **Ranking.** Every request pattern is swept under several mask and level settings. A design that ranks levels wrongly, breaks ties toward the higher index, or lets a masked line in reports the wrong address.
- **Nesting.** Every ordered pair of serviced vector and newcomer is tried. A design that compares with greater-or-equal instead of strictly greater lets an equal-level request break in.
- **Acknowledge and return handling.** A stray acknowledge must not block later requests. An acknowledge and a return in the same cycle must leave the new level active. A design that pops on that cycle re-raises the request at once.
- **Freeze at acknowledge.** A higher request arriving during the acknowledge must not overwrite the frozen address, and must then be raised on the following cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W = 2;
  typedef enum logic [LVL_W-1:0] {
    LV_NONE = 2'd0,
    LV_LOW  = 2'd1,
    LV_HIGH = 2'd2,
    LV_TOP  = 2'd3
  } irq_lvl_e;
  localparam int NUM_LVL = 3;
endpackage

// File: rtl/irq_level_map.sv
module irq_level_map
  import irq_pkg::*;
#(
  parameter int NUM_VEC  = 8,
  parameter int NUM_XCAP = 2
) (
  input  logic [NUM_VEC-1:0]            lvl_hi,
  output logic [NUM_VEC-1:0][LVL_W-1:0] lvl_o
);
  for (genvar i = 0; i < NUM_VEC; i++) begin : g_map
    if (i < NUM_XCAP) begin : g_top_capable
      assign lvl_o[i] = lvl_hi[i] ? LV_TOP : LV_LOW;
    end else begin : g_high_capable
      assign lvl_o[i] = lvl_hi[i] ? LV_HIGH : LV_LOW;
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_pkg::*;
#(
  parameter int NUM_VEC = 8,
  localparam int IDX_W  = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0]            req_elig,
  input  logic [NUM_VEC-1:0][LVL_W-1:0] lvl,
  input  logic [LVL_W-1:0]              cur_lvl,
  output logic                          cand_valid,
  output logic [IDX_W-1:0]              cand_idx,
  output logic [LVL_W-1:0]              cand_lvl
);
  // Scan from the top index down; ">=" lets a lower index take over a tie.
  always_comb begin
    cand_valid = 1'b0;
    cand_idx   = '0;
    cand_lvl   = LV_NONE;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (req_elig[i] && (lvl[i] > cur_lvl) && (lvl[i] >= cand_lvl)) begin
        cand_valid = 1'b1;
        cand_idx   = IDX_W'(i);
        cand_lvl   = lvl[i];
      end
    end
  end
endmodule

// File: rtl/irq_active_set.sv
module irq_active_set
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [LVL_W-1:0] push_lvl,
  input  logic             pop,
  output logic [LVL_W-1:0] cur_lvl
);
  // Nesting is strictly rising, so a set of active levels acts as the stack.
  logic [NUM_LVL-1:0] act_q, act_n;
  logic               act_en;

  always_comb begin
    cur_lvl = LV_NONE;
    for (int k = 0; k < NUM_LVL; k++) begin
      if (act_q[k]) cur_lvl = LVL_W'(k + 1);
    end
  end

  always_comb begin
    act_n  = act_q;
    act_en = push | pop;
    if (push) begin
      act_n[push_lvl - 2'd1] = 1'b1;
    end else if (pop && cur_lvl != LV_NONE) begin
      act_n[cur_lvl - 2'd1] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_q <= '0;
    else if (act_en) act_q <= act_n;
  end

  assert_push_above_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (push_lvl > cur_lvl));
  assert_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && act_q == '0) |=> (act_q == '0));
  assert_pop_lowers_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && act_q != '0) |=> (cur_lvl < $past(cur_lvl)));
endmodule

// File: rtl/irq_nest_arb.sv
module irq_nest_arb
  import irq_pkg::*;
#(
  parameter int NUM_VEC    = 8,
  parameter int NUM_XCAP   = 2,
  parameter int ADDR_W     = 8,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_VEC-1:0] irq_req,
  input  logic [NUM_VEC-1:0] irq_mask,
  input  logic [NUM_VEC-1:0] lvl_hi,
  input  logic              cpu_ack,
  input  logic              cpu_reti,
  output logic              cpu_irq,
  output logic [ADDR_W-1:0] vec_addr
);
  localparam int IDX_W = $clog2(NUM_VEC);

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rs_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  logic [NUM_VEC-1:0][LVL_W-1:0] lvl;
  logic [LVL_W-1:0]              cur_lvl, cand_lvl;
  logic                          cand_valid;
  logic [IDX_W-1:0]              cand_idx;
  logic [NUM_VEC-1:0]            req_elig;

  assign req_elig = irq_req & ~irq_mask;

  irq_level_map #(.NUM_VEC(NUM_VEC), .NUM_XCAP(NUM_XCAP)) map_i (
    .lvl_hi (lvl_hi),
    .lvl_o  (lvl)
  );

  irq_pick #(.NUM_VEC(NUM_VEC)) pick_i (
    .req_elig   (req_elig),
    .lvl        (lvl),
    .cur_lvl    (cur_lvl),
    .cand_valid (cand_valid),
    .cand_idx   (cand_idx),
    .cand_lvl   (cand_lvl)
  );

  logic take, pop;
  logic [LVL_W-1:0] pend_q, pend_n;
  logic             irq_q, irq_n;
  logic [ADDR_W-1:0] vec_q, vec_n;
  logic             out_en;

  assign take = cpu_ack & irq_q;
  assign pop  = cpu_reti & ~take;

  irq_active_set act_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .push     (take),
    .push_lvl (pend_q),
    .pop      (pop),
    .cur_lvl  (cur_lvl)
  );

  always_comb begin
    irq_n  = irq_q;
    vec_n  = vec_q;
    pend_n = pend_q;
    out_en = 1'b0;
    if (take) begin
      irq_n  = 1'b0;
      out_en = 1'b1;
    end else if (cand_valid) begin
      irq_n  = 1'b1;
      vec_n  = ADDR_W'(VEC_BASE + int'(cand_idx) * VEC_STRIDE);
      pend_n = cand_lvl;
      out_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irq_q  <= 1'b0;
      vec_q  <= '0;
      pend_q <= LV_NONE;
    end else if (out_en) begin
      irq_q  <= irq_n;
      vec_q  <= vec_n;
      pend_q <= pend_n;
    end
  end

  assign cpu_irq  = irq_q;
  assign vec_addr = vec_q;

  assert_pick_requested_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cand_valid |-> (irq_req[cand_idx] && !irq_mask[cand_idx]));
  assert_pick_above_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cand_valid && !take) |=> (cpu_irq && pend_q > cur_lvl));
  assert_held_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_irq && !cpu_ack) |=> cpu_irq);
  assert_ack_drops_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_irq && cpu_ack) |=> (!cpu_irq && $stable(vec_addr)));
  assert_stray_ack_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_ack && !cpu_irq && !cpu_reti) |=> $stable(cur_lvl));
endmodule

// File: tb/irq_nest_arb_tb.sv
module irq_nest_arb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 100000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_req, irq_mask, lvl_hi;
  logic       cpu_ack, cpu_reti;
  logic       cpu_irq;
  logic [7:0] vec_addr;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_nest_arb dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_mask(irq_mask),
    .lvl_hi(lvl_hi), .cpu_ack(cpu_ack), .cpu_reti(cpu_reti),
    .cpu_irq(cpu_irq), .vec_addr(vec_addr)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_LIMIT) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog (all R): actual %0d cycles, expected < %0d", cyc, WD_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // 1 = low, 2 = high, 3 = highest
  function automatic int lv(input int i, input logic hi);
    if (!hi) return 1;
    return (i < 2) ? 3 : 2;
  endfunction

  function automatic int addr_of(input int i);
    return 3 + 8 * i;
  endfunction

  task automatic ack_pulse();
    cpu_ack = 1'b1; step(); cpu_ack = 1'b0;
  endtask

  task automatic reti_pulse();
    cpu_reti = 1'b1; step(); cpu_reti = 1'b0;
  endtask

  initial begin
    logic [7:0] mpat [3];
    logic [7:0] lpat [4];
    mpat[0] = 8'h00; mpat[1] = 8'h55; mpat[2] = 8'hF0;
    lpat[0] = 8'h00; lpat[1] = 8'hFF; lpat[2] = 8'hA5; lpat[3] = 8'h3C;

    rst_n = 1'b0; irq_req = '0; irq_mask = '0; lvl_hi = '0;
    cpu_ack = 1'b0; cpu_reti = 1'b0;
    step(); step();
    chk("R1 irq in reset", int'(cpu_irq), 0);
    chk("R1 addr in reset", int'(vec_addr), 0);
    rst_n = 1'b1;
    step(); step(); step();
    chk("R1 irq after reset", int'(cpu_irq), 0);
    chk("R1 addr after reset", int'(vec_addr), 0);

    // R2 R3 R4 R5: sweep from the idle state
    for (int mi = 0; mi < 3; mi++) begin
      for (int li = 0; li < 4; li++) begin
        for (int r = 0; r < 256; r++) begin
          int best, bl;
          irq_mask = mpat[mi]; lvl_hi = lpat[li]; irq_req = 8'(r);
          step();
          best = -1; bl = 0;
          for (int i = 0; i < 8; i++) begin
            if (irq_req[i] && !irq_mask[i] && lv(i, lvl_hi[i]) > bl) begin
              bl = lv(i, lvl_hi[i]); best = i;
            end
          end
          chk("R3 R5 irq raised", int'(cpu_irq), (best >= 0) ? 1 : 0);
          if (best >= 0) chk("R2 R4 winner address", int'(vec_addr), addr_of(best));
          if (cpu_irq) begin
            irq_req = '0;
            ack_pulse();
            reti_pulse();
          end else begin
            irq_req = '0;
          end
        end
      end
    end
    irq_mask = '0;

    // R6: every serviced/newcomer pair
    for (int li = 0; li < 4; li++) begin
      for (int a = 0; a < 8; a++) begin
        for (int b = 0; b < 8; b++) begin
          int ex;
          lvl_hi = lpat[li];
          irq_req = 8'(1 << a);
          step();
          irq_req = '0;
          ack_pulse();
          irq_req = 8'(1 << b);
          step();
          ex = (lv(b, lvl_hi[b]) > lv(a, lvl_hi[a])) ? 1 : 0;
          chk("R6 nested accept", int'(cpu_irq), ex);
          if (ex == 1) chk("R6 nested address", int'(vec_addr), addr_of(b));
          irq_req = '0;
          if (cpu_irq) begin ack_pulse(); reti_pulse(); end
          reti_pulse();
        end
      end
    end

    // R7: held after request removal; address upgrades while pending
    lvl_hi = 8'h00;
    irq_req = 8'h80; step();
    irq_req = 8'h00; step(); step();
    chk("R7 irq held", int'(cpu_irq), 1);
    chk("R7 addr held", int'(vec_addr), addr_of(7));
    irq_req = 8'h08; step();
    chk("R7 addr follows better", int'(vec_addr), addr_of(3));
    irq_req = '0; ack_pulse(); reti_pulse();

    // R8: higher arrival during the acknowledge edge
    lvl_hi = 8'h21;
    irq_req = 8'h20; step();
    chk("R8 pending vec5", int'(vec_addr), addr_of(5));
    irq_req = 8'h01; cpu_ack = 1'b1; step(); cpu_ack = 1'b0;
    chk("R8 irq dropped", int'(cpu_irq), 0);
    chk("R8 addr frozen", int'(vec_addr), addr_of(5));
    step();
    chk("R8 higher raised next", int'(cpu_irq), 1);
    chk("R8 higher address", int'(vec_addr), addr_of(0));
    irq_req = '0; ack_pulse(); reti_pulse(); reti_pulse();

    // R9: return with nothing active, then plain acceptance
    lvl_hi = 8'h00;
    reti_pulse(); reti_pulse();
    irq_req = 8'h40; step();
    chk("R9 accept when idle", int'(cpu_irq), 1);
    irq_req = '0; ack_pulse(); reti_pulse();

    // R10: stray acknowledge activates nothing
    ack_pulse(); step();
    irq_req = 8'h80; step();
    chk("R10 stray ack ignored", int'(cpu_irq), 1);
    irq_req = '0; ack_pulse(); reti_pulse();

    // R11: acknowledge wins over a return in the same cycle
    lvl_hi = 8'h04;
    irq_req = 8'h02; step();
    irq_req = '0; ack_pulse();
    irq_req = 8'h04; step();
    chk("R11 high pending", int'(cpu_irq), 1);
    cpu_ack = 1'b1; cpu_reti = 1'b1; step(); cpu_ack = 1'b0; cpu_reti = 1'b0;
    step();
    chk("R11 reti ignored, high still active", int'(cpu_irq), 0);
    reti_pulse(); step();
    chk("R11 back to low, high re-raised", int'(cpu_irq), 1);
    irq_req = '0; ack_pulse(); reti_pulse(); reti_pulse();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule